// File: doc/BRIEF.md
# Cartridge Bank-Switching Address Mapper

This block sits on a game cartridge between the console buses and the memories on the board: 128K of program ROM cut into eight 16K banks, an 8K battery-backed work RAM, and an 8K pattern RAM on the video bus. It decodes each CPU and PPU address combinationally into chip selects and physical address lines. It also drives the video-memory A10 line, which sets how the console's two internal nametables are arranged.

Software changes the mapping by storing to the ROM window. A store to 8000-FFFF never reaches the ROM. Address bits 14:13 of the store choose a target register. One is a control register that holds a 2-bit banking mode and a mirroring bit. The other is a 3-bit bank register. After reset the block maps the last bank at C000-FFFF, so the reset vector at the top of that bank is reachable before software writes anything.

All ports are plain control and address pins. No data stream passes through the block, so there is no handshake and no back-pressure.

Top module: `cart_mapper`

## Requirements
- R1: After reset the mode is 16K with the upper half fixed, the bank register is 0 and mirroring is vertical. A read of 8000 gives ROM address 00000, and a read of C000 gives ROM address 1C000.
- R2: CPU addresses 6000-7FFF assert `wram_cs` for both reads and writes, with `wram_addr` equal to CPU bits 12:0.
- R3: CPU addresses below 6000 assert neither `rom_cs` nor `wram_cs`.
- R4: `rom_cs` is high exactly for reads (`cpu_wr` low) of 8000-FFFF. `rom_addr` is {16K bank number, CPU bits 13:0}.
- R5: A store (`cpu_wr` high) to 8000-FFFF with CPU bits 14:13 = 00 loads the control register: data bits 1:0 are the mode, and data bit 2 is mirroring (1 = horizontal, 0 = vertical). Bits 14:13 = 01 load the bank register from data bits 2:0. Bits 10 and 11 change nothing. The new value applies from the next clock cycle.
- R6: Mode 3 (upper fixed): 8000-BFFF maps to the bank register, and C000-FFFF maps to bank 7.
- R7: Mode 2 (lower fixed): 8000-BFFF maps to bank 0, and C000-FFFF maps to the bank register.
- R8: Modes 0 and 1 (32K): the 16K bank number is {bank register bits 2:1, CPU bit 14}. Bank register bit 0 is ignored.
- R9: PPU addresses 0000-1FFF assert `chr_cs` with `chr_addr` equal to PPU bits 12:0. Higher PPU addresses do not assert it.
- R10: `vram_a10` equals PPU bit 11 under horizontal mirroring and PPU bit 10 under vertical mirroring.
- R11: Writes to 6000-7FFF, writes below 6000 and reads anywhere leave the mode, bank and mirroring registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write strobe, high for a store |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 14 | PPU address |
| rom_cs | output | 1 | Program ROM select |
| rom_addr | output | 17 | Program ROM physical address |
| wram_cs | output | 1 | Work RAM select |
| wram_addr | output | 13 | Work RAM address |
| chr_cs | output | 1 | Pattern RAM select |
| chr_addr | output | 13 | Pattern RAM address |
| vram_a10 | output | 1 | Nametable RAM A10 line |

## Verification
The selects, the physical addresses and `vram_a10` are combinational. They are due in the same cycle the addresses are driven. A register store takes effect one clock edge later. The bench therefore drives all inputs on the falling edge and compares outputs shortly after, before the next rising edge. It advances its own register model only after that comparison, so a store is reflected from the following cycle on.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
  localparam int CPU_AW = 16;
  localparam int PPU_AW = 14;

  typedef enum logic [1:0] {
    MODE_WHOLE_A   = 2'b00,
    MODE_WHOLE_B   = 2'b01,
    MODE_LOW_FIXED = 2'b10,
    MODE_HIGH_FIXED = 2'b11
  } prg_mode_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'b00,
    SEL_BANK = 2'b01
  } reg_sel_e;
endpackage

// File: rtl/cart_map_regs.sv
module cart_map_regs
  import cart_map_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        sel,
  input  logic [7:0]        wdata,
  output prg_mode_e         mode_q,
  output logic [BANK_W-1:0] bank_q,
  output logic              hmir_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_HIGH_FIXED;
      bank_q <= '0;
      hmir_q <= 1'b0;
    end else if (wr_en) begin
      case (sel)
        SEL_CTRL: begin
          mode_q <= prg_mode_e'(wdata[1:0]);
          hmir_q <= wdata[2];
        end
        SEL_BANK: bank_q <= wdata[BANK_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cart_prg_decode.sv
module cart_prg_decode
  import cart_map_pkg::*;
#(
  parameter int BANK_W  = 3,
  parameter int WIN_AW  = 14,
  parameter int WRAM_AW = 13
) (
  input  logic [CPU_AW-1:0]        cpu_addr,
  input  logic                     cpu_wr,
  input  prg_mode_e                mode,
  input  logic [BANK_W-1:0]        bank,
  output logic                     rom_cs,
  output logic [BANK_W+WIN_AW-1:0] rom_addr,
  output logic                     wram_cs,
  output logic [WRAM_AW-1:0]       wram_addr
);
  localparam logic [CPU_AW-1:0] WRAM_BASE = 16'h6000;
  localparam int                PAGE_W    = CPU_AW - WRAM_AW;
  localparam logic [PAGE_W-1:0] WRAM_PAGE = WRAM_BASE[CPU_AW-1:WRAM_AW];
  localparam logic [BANK_W-1:0] LAST_BANK = '1;

  logic              upper_half;
  logic [BANK_W-1:0] bank_sel;

  assign upper_half = cpu_addr[WIN_AW];

  always_comb begin
    case (mode)
      MODE_HIGH_FIXED: bank_sel = upper_half ? LAST_BANK : bank;
      MODE_LOW_FIXED:  bank_sel = upper_half ? bank : '0;
      default:         bank_sel = {bank[BANK_W-1:1], upper_half};
    endcase
  end

  assign rom_cs    = cpu_addr[CPU_AW-1] & ~cpu_wr;
  assign rom_addr  = {bank_sel, cpu_addr[WIN_AW-1:0]};
  assign wram_cs   = (cpu_addr[CPU_AW-1:WRAM_AW] == WRAM_PAGE);
  assign wram_addr = cpu_addr[WRAM_AW-1:0];
endmodule

// File: rtl/cart_ppu_decode.sv
module cart_ppu_decode
  import cart_map_pkg::*;
#(
  parameter int CHR_AW = 13
) (
  input  logic [PPU_AW-1:0] ppu_addr,
  input  logic              hmir,
  output logic              chr_cs,
  output logic [CHR_AW-1:0] chr_addr,
  output logic              vram_a10
);
  localparam int PAGE_W = PPU_AW - CHR_AW;

  assign chr_cs   = (ppu_addr[PPU_AW-1:CHR_AW] == {PAGE_W{1'b0}});
  assign chr_addr = ppu_addr[CHR_AW-1:0];
  assign vram_a10 = hmir ? ppu_addr[11] : ppu_addr[10];
endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
  import cart_map_pkg::*;
#(
  parameter int PRG_BANKS = 8,
  parameter int WIN_AW    = 14,
  parameter int WRAM_AW   = 13,
  parameter int CHR_AW    = 13,
  localparam int BANK_W   = $clog2(PRG_BANKS),
  localparam int ROM_AW   = BANK_W + WIN_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic              cpu_wr,
  input  logic [7:0]        cpu_wdata,
  input  logic [13:0]       ppu_addr,
  output logic              rom_cs,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              wram_cs,
  output logic [WRAM_AW-1:0] wram_addr,
  output logic              chr_cs,
  output logic [CHR_AW-1:0] chr_addr,
  output logic              vram_a10
);
  prg_mode_e         mode_q;
  logic [BANK_W-1:0] bank_q;
  logic              hmir_q;
  logic              reg_wr;

  assign reg_wr = cpu_wr & cpu_addr[CPU_AW-1];

  cart_map_regs #(.BANK_W(BANK_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr),
    .sel    (cpu_addr[WIN_AW:WIN_AW-1]),
    .wdata  (cpu_wdata),
    .mode_q (mode_q),
    .bank_q (bank_q),
    .hmir_q (hmir_q)
  );

  cart_prg_decode #(.BANK_W(BANK_W), .WIN_AW(WIN_AW), .WRAM_AW(WRAM_AW)) u_prg (
    .cpu_addr  (cpu_addr),
    .cpu_wr    (cpu_wr),
    .mode      (mode_q),
    .bank      (bank_q),
    .rom_cs    (rom_cs),
    .rom_addr  (rom_addr),
    .wram_cs   (wram_cs),
    .wram_addr (wram_addr)
  );

  cart_ppu_decode #(.CHR_AW(CHR_AW)) u_ppu (
    .ppu_addr (ppu_addr),
    .hmir     (hmir_q),
    .chr_cs   (chr_cs),
    .chr_addr (chr_addr),
    .vram_a10 (vram_a10)
  );
endmodule

// File: rtl/cart_mapper_chk.sv
module cart_mapper_chk #(
  parameter int BANK_W = 3,
  parameter int ROM_AW = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cpu_addr,
  input logic              cpu_wr,
  input logic [7:0]        cpu_wdata,
  input logic [13:0]       ppu_addr,
  input logic              rom_cs,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              wram_cs,
  input logic              chr_cs,
  input logic              vram_a10,
  input logic [1:0]        mode_q,
  input logic [BANK_W-1:0] bank_q,
  input logic              hmir_q
);
  localparam int WIN_AW = ROM_AW - BANK_W;

  // R3
  low_space_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr < 16'h6000) |-> (!rom_cs && !wram_cs));

  // R4
  rom_store_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |-> !rom_cs);

  // R5
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b101) |=> (bank_q == $past(cpu_wdata[BANK_W-1:0])));

  // R6
  top_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b11 && rom_cs && cpu_addr[WIN_AW]) |-> (rom_addr[ROM_AW-1:WIN_AW] == {BANK_W{1'b1}}));

  // R7
  bottom_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b10 && rom_cs && !cpu_addr[WIN_AW]) |-> (rom_addr[ROM_AW-1:WIN_AW] == '0));

  // R9
  chr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chr_cs |-> (ppu_addr < 14'h2000));

  // R10
  a10_horiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hmir_q |-> (vram_a10 == ppu_addr[11]));

  // R11
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_addr[15]) |=> ($stable(bank_q) && $stable(mode_q) && $stable(hmir_q)));
endmodule

bind cart_mapper cart_mapper_chk #(.BANK_W(BANK_W), .ROM_AW(ROM_AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_addr  (cpu_addr),
  .cpu_wr    (cpu_wr),
  .cpu_wdata (cpu_wdata),
  .ppu_addr  (ppu_addr),
  .rom_cs    (rom_cs),
  .rom_addr  (rom_addr),
  .wram_cs   (wram_cs),
  .chr_cs    (chr_cs),
  .vram_a10  (vram_a10),
  .mode_q    (mode_q),
  .bank_q    (bank_q),
  .hmir_q    (hmir_q)
);

// File: tb/cart_mapper_tb.sv
module cart_mapper_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [13:0] ppu_addr = '0;
  logic        rom_cs, wram_cs, chr_cs, vram_a10;
  logic [16:0] rom_addr;
  logic [12:0] wram_addr, chr_addr;

  int n_tests = 0;
  int n_fail  = 0;

  logic [1:0] m_mode = 2'b11;
  logic [2:0] m_bank = 3'd0;
  logic       m_hmir = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cart_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .ppu_addr(ppu_addr), .rom_cs(rom_cs),
    .rom_addr(rom_addr), .wram_cs(wram_cs), .wram_addr(wram_addr),
    .chr_cs(chr_cs), .chr_addr(chr_addr), .vram_a10(vram_a10)
  );

  function automatic logic [16:0] exp_rom(logic [15:0] a, logic [1:0] md, logic [2:0] bk);
    logic [2:0] b;
    case (md)
      2'b11:   b = a[14] ? 3'd7 : bk;
      2'b10:   b = a[14] ? bk : 3'd0;
      default: b = {bk[2:1], a[14]};
    endcase
    return {b, a[13:0]};
  endfunction

  function automatic string rom_tag(logic [1:0] md);
    if (md == 2'b11) return "R6";
    if (md == 2'b10) return "R7";
    return "R8";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (addr=%h ppu=%h)", tag, act, exp, cpu_addr, ppu_addr);
    end
  endtask

  task automatic step(logic [15:0] a, logic w, logic [7:0] d, logic [13:0] p);
    logic exp_rcs, exp_wcs, exp_ccs;
    @(negedge clk);
    cpu_addr = a; cpu_wr = w; cpu_wdata = d; ppu_addr = p;
    #1;
    exp_rcs = a[15] & ~w;
    exp_wcs = (a[15:13] == 3'b011);
    exp_ccs = (p < 14'h2000);
    chk(a < 16'h6000 ? "R3" : "R4", {31'd0, rom_cs}, {31'd0, exp_rcs});
    if (exp_rcs) chk(rom_tag(m_mode), {15'd0, rom_addr}, {15'd0, exp_rom(a, m_mode, m_bank)});
    chk(a < 16'h6000 ? "R3" : "R2", {31'd0, wram_cs}, {31'd0, exp_wcs});
    if (exp_wcs) chk("R2", {19'd0, wram_addr}, {19'd0, a[12:0]});
    chk("R9", {31'd0, chr_cs}, {31'd0, exp_ccs});
    if (exp_ccs) chk("R9", {19'd0, chr_addr}, {19'd0, p[12:0]});
    chk("R10", {31'd0, vram_a10}, {31'd0, (m_hmir ? p[11] : p[10])});
    if (w && a[15]) begin
      if (a[14:13] == 2'b00) begin m_mode = d[1:0]; m_hmir = d[2]; end
      else if (a[14:13] == 2'b01) m_bank = d[2:0];
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20231));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset mapping
    step(16'h8000, 1'b0, 8'h00, 14'h0400);
    chk("R1", {15'd0, rom_addr}, 32'h00000);
    chk("R1", {31'd0, vram_a10}, 32'd1);
    step(16'hC000, 1'b0, 8'h00, 14'h0800);
    chk("R1", {15'd0, rom_addr}, 32'h1C000);
    chk("R1", {31'd0, vram_a10}, 32'd0);
    step(16'hFFFC, 1'b0, 8'h00, 14'h2000);
    chk("R1", {15'd0, rom_addr}, 32'h1FFFC);
    // R5 R6: bank 3 in upper-fixed mode
    step(16'hA000, 1'b1, 8'h03, 14'h0000);
    step(16'h8123, 1'b0, 8'h00, 14'h0000);
    chk("R6", {15'd0, rom_addr}, 32'h0C123);
    // R7: lower fixed, bank 5
    step(16'h8000, 1'b1, 8'h02, 14'h0000);
    step(16'hA000, 1'b1, 8'h05, 14'h0000);
    step(16'h8010, 1'b0, 8'h00, 14'h0000);
    chk("R7", {15'd0, rom_addr}, 32'h00010);
    step(16'hC010, 1'b0, 8'h00, 14'h0000);
    chk("R7", {15'd0, rom_addr}, 32'h14010);
    // R8 R10: 32K mode with horizontal mirroring
    step(16'h9FFF, 1'b1, 8'h04, 14'h0000);
    step(16'h8000, 1'b0, 8'h00, 14'h0800);
    chk("R8", {15'd0, rom_addr}, 32'h10000);
    chk("R10", {31'd0, vram_a10}, 32'd1);
    step(16'hC000, 1'b0, 8'h00, 14'h0400);
    chk("R8", {15'd0, rom_addr}, 32'h14000);
    chk("R10", {31'd0, vram_a10}, 32'd0);
    // R11 R5: ignored stores (WRAM write, low write, unused selects)
    step(16'h6000, 1'b1, 8'h01, 14'h0000);
    step(16'h1234, 1'b1, 8'h01, 14'h0000);
    step(16'hC000, 1'b1, 8'h02, 14'h0000);
    step(16'hE000, 1'b1, 8'h03, 14'h0000);
    step(16'hC000, 1'b0, 8'h00, 14'h0800);
    chk("R11", {15'd0, rom_addr}, 32'h14000);
    chk("R11", {31'd0, vram_a10}, 32'd1);
    // R2 R3 R9 boundaries
    step(16'h5FFF, 1'b0, 8'h00, 14'h1FFF);
    step(16'h7FFF, 1'b1, 8'h00, 14'h2000);
    step(16'h7FFF, 1'b0, 8'h00, 14'h3FFF);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      logic        w;
      a = 16'($urandom);
      w = ($urandom % 3) == 0;
      step(a, w, 8'($urandom), 14'($urandom));
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule